// File: doc/BRIEF.md
# Residual Digital Decision Unit

This block is the last digital stage of an analog in-memory inference datapath. It sits behind the converter that digitises each aggregated distance. A task streams one signed distance per candidate iteration into the block, each with a candidate index and a flag that marks the final iteration. The opcode held on the op input during the task decides how the stream is reduced:

- running maximum or minimum, reported together with the winning index;
- plain sum, or mean;
- a threshold test on the sum;
- one of four activations applied to the sum: rectifier, sign, or piecewise-linear tanh or sigmoid.

The converter precision can be set from 4 to 8 bits. Each sample arrives on an 8-bit bus. Only its low precision bits are significant, and the block sign-extends them itself. A pulse on start marks the first sample of a task and discards everything accumulated before it. One decision leaves the block per task, marked by a single-cycle valid pulse. For most opcodes the result is due in the cycle right after the final sample. For mean, a sequential divider adds a fixed number of cycles.

Top module: `resid_decide`

## Requirements
- R1: After reset, out_valid, out_value and out_idx are all 0.
- R2: Each sample is the low P bits of in_data, sign-extended, where P is prec clamped to the range 4..8. A prec below 4 acts as 4 and a prec above 8 acts as 8.
- R3: Opcode 0 (maximum) reports the largest sample of the task, sign-extended into out_value, with its candidate index on out_idx. On equal values the earliest index is kept.
- R4: Opcode 1 (minimum) reports the smallest sample and its index. On equal values the earliest index is kept.
- R5: Opcode 3 (sum) reports the signed sum of all samples of the task, and out_idx is 0. Opcodes 9 to 15 report 0.
- R6: Opcode 2 (mean) reports sum divided by sample count, truncated toward zero. out_valid rises 17 cycles after the clock edge that takes the last sample, and stays low for the 16 cycles before that.
- R7: Opcode 4 (threshold) reports 1 when the sum is greater than or equal to the signed thresh input, and 0 otherwise.
- R8: Opcode 5 (rectifier) reports the sum when it is non-negative, and 0 otherwise.
- R9: Opcode 6 (sign) reports +1 when the sum is greater than or equal to 0, and -1 otherwise.
- R10: Opcode 7 (tanh) treats the sum s as Q3.4 and reports a Q3.4 value:
  - 16 for s >= 32, and -16 for s <= -32;
  - otherwise, with m = |s|, the magnitude is m for m <= 8, 8 + (m-8)/2 for m <= 16, and 12 + (m-16)/4 above that, with the division truncated;
  - the result carries the sign of s.
- R11: Opcode 8 (sigmoid) reports, in Q3.4, 16 for s >= 32 and 0 for s <= -32. Otherwise it reports 8 + floor(s/4).
- R12: For every opcode except mean, out_valid is high for exactly the one cycle that follows the clock edge taking the last-flagged sample. out_value and out_idx hold the result in that cycle.
- R13: A sample presented with start high is the first sample of a new task. No value, index or count from earlier samples affects the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks the first sample of a task and clears the accumulated state |
| op | input | 4 | Decision opcode, held stable for the whole task |
| prec | input | 4 | Converter precision in bits, clamped to 4..8 |
| thresh | input | 16 | Signed threshold for opcode 4 |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | 8 | Raw sample; the low prec bits are significant |
| in_idx | input | 8 | Candidate index of the sample |
| in_last | input | 1 | Sample is the final one of the task |
| out_valid | output | 1 | Result pulse |
| out_value | output | 16 | Signed decision value |
| out_idx | output | 8 | Winning index for maximum or minimum, otherwise 0 |

## Verification
For every opcode except mean, the result registers load on the same edge that takes the last-flagged sample. The bench therefore samples 1 ns after that edge and checks out_valid, the value and the index there. One cycle later it checks that out_valid has fallen again. For mean, the divider needs one load edge, then one edge per bit of the 16-bit sum, then one output register. The bench counts edges from the last sample until out_valid rises and requires exactly 17. Inputs change only on falling edges, so each sample lands on a known rising edge.

// File: rtl/resid_decide_pkg.sv
package resid_decide_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int IDX_W_DEF  = 8;
    localparam int PREC_MIN   = 4;
    localparam int FRAC_W     = 4;

    localparam int Q_ONE  = 1 << FRAC_W;
    localparam int Q_HALF = Q_ONE / 2;
    localparam int Q_MID  = Q_HALF + Q_HALF / 2;
    localparam int Q_SAT  = 2 * Q_ONE;

    typedef enum logic [3:0] {
        OP_MAX  = 4'd0,
        OP_MIN  = 4'd1,
        OP_MEAN = 4'd2,
        OP_SUM  = 4'd3,
        OP_THR  = 4'd4,
        OP_RELU = 4'd5,
        OP_SIGN = 4'd6,
        OP_TANH = 4'd7,
        OP_SIGM = 4'd8
    } op_e;

    typedef struct packed {
        logic take;
        logic clr;
        logic fin;
    } ctl_t;

    function automatic int clamp_prec(input int p, input int maxw);
        int r;
        r = p;
        if (r < PREC_MIN) r = PREC_MIN;
        if (r > maxw)     r = maxw;
        return r;
    endfunction

endpackage

// File: rtl/rd_extreme.sv
module rd_extreme #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     take,
    input  logic                     want_min,
    input  logic signed [DATA_W-1:0] smp,
    input  logic [IDX_W-1:0]         idx,
    output logic signed [DATA_W-1:0] nxt_val,
    output logic [IDX_W-1:0]         nxt_idx
);
    logic                     have_q;
    logic signed [DATA_W-1:0] val_q;
    logic [IDX_W-1:0]         idx_q;
    logic                     base_have;
    logic                     better;

    always_comb begin
        base_have = clr ? 1'b0 : have_q;
        better    = want_min ? (smp < val_q) : (smp > val_q);
        if (take && (!base_have || better)) begin
            nxt_val = smp;
            nxt_idx = idx;
        end else if (base_have) begin
            nxt_val = val_q;
            nxt_idx = idx_q;
        end else begin
            nxt_val = '0;
            nxt_idx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            val_q  <= '0;
            idx_q  <= '0;
        end else begin
            have_q <= base_have | take;
            val_q  <= nxt_val;
            idx_q  <= nxt_idx;
        end
    end
endmodule

// File: rtl/rd_accum.sv
module rd_accum #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16,
    parameter int CNT_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     take,
    input  logic signed [DATA_W-1:0] smp,
    output logic signed [ACC_W-1:0]  nxt_sum,
    output logic [CNT_W-1:0]         nxt_cnt
);
    logic signed [ACC_W-1:0] sum_q;
    logic [CNT_W-1:0]        cnt_q;
    logic signed [ACC_W-1:0] base_sum;
    logic [CNT_W-1:0]        base_cnt;
    logic signed [ACC_W-1:0] smp_x;

    always_comb begin
        base_sum = clr ? '0 : sum_q;
        base_cnt = clr ? '0 : cnt_q;
        smp_x    = {{(ACC_W-DATA_W){smp[DATA_W-1]}}, smp};
        nxt_sum  = take ? base_sum + smp_x : base_sum;
        nxt_cnt  = take ? base_cnt + CNT_W'(1) : base_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else begin
            sum_q <= nxt_sum;
            cnt_q <= nxt_cnt;
        end
    end
endmodule

// File: rtl/rd_activate.sv
module rd_activate
    import resid_decide_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e                 op,
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] thr,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] ONE  = W'(Q_ONE);
    localparam logic signed [W-1:0] HALF = W'(Q_HALF);
    localparam logic signed [W-1:0] MID  = W'(Q_MID);
    localparam logic signed [W-1:0] SAT  = W'(Q_SAT);

    logic signed [W-1:0] mag;
    logic signed [W-1:0] seg;

    always_comb begin
        mag = x[W-1] ? -x : x;
        if (mag <= HALF)     seg = mag;
        else if (mag <= ONE) seg = HALF + ((mag - HALF) >>> 1);
        else                 seg = MID + ((mag - ONE) >>> 2);

        case (op)
            OP_THR:  y = (x >= thr) ? W'(1) : '0;
            OP_RELU: y = x[W-1] ? '0 : x;
            OP_SIGN: y = x[W-1] ? -W'(1) : W'(1);
            OP_TANH: begin
                if (x >= SAT)       y = ONE;
                else if (x <= -SAT) y = -ONE;
                else                y = x[W-1] ? -seg : seg;
            end
            OP_SIGM: begin
                if (x >= SAT)       y = ONE;
                else if (x <= -SAT) y = '0;
                else                y = HALF + (x >>> 2);
            end
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rd_divider.sv
module rd_divider #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic signed [W-1:0] dividend,
    input  logic [W-1:0]        divisor,
    output logic                done,
    output logic signed [W-1:0] quotient
);
    localparam int SW = $clog2(W + 1);

    logic          busy;
    logic [SW-1:0] steps;
    logic [W-1:0]  rem, quo, dvsr;
    logic          neg;
    logic [W:0]    shifted;
    logic          fits;
    logic [W-1:0]  rem_n, quo_n;
    logic [W:0]    diff;

    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvsr};
        fits    = shifted >= {1'b0, dvsr};
        rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_n   = {quo[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            steps    <= '0;
            rem      <= '0;
            quo      <= '0;
            dvsr     <= '0;
            neg      <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy  <= 1'b1;
                steps <= SW'(W);
                rem   <= '0;
                quo   <= dividend[W-1] ? W'(-dividend) : W'(dividend);
                dvsr  <= divisor;
                neg   <= dividend[W-1];
            end else if (busy) begin
                rem   <= rem_n;
                quo   <= quo_n;
                steps <= steps - SW'(1);
                if (steps == SW'(1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    quotient <= neg ? -$signed(quo_n) : $signed(quo_n);
                end
            end
        end
    end
endmodule

// File: rtl/resid_decide.sv
module resid_decide
    import resid_decide_pkg::*;
#(
    parameter int DATA_W  = DATA_W_DEF,
    parameter int IDX_W   = IDX_W_DEF,
    parameter int PREC_W  = 4,
    localparam int ACC_W  = DATA_W + IDX_W,
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [3:0]              op,
    input  logic [PREC_W-1:0]       prec,
    input  logic signed [ACC_W-1:0] thresh,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    input  logic [IDX_W-1:0]        in_idx,
    input  logic                    in_last,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_value,
    output logic [IDX_W-1:0]        out_idx
);
    op_e                     op_i;
    ctl_t                    ctl;
    int                      pc;
    logic signed [DATA_W-1:0] smp;
    logic signed [DATA_W-1:0] ext_val;
    logic [IDX_W-1:0]         ext_idx;
    logic signed [ACC_W-1:0]  nxt_sum;
    logic [CNT_W-1:0]         nxt_cnt;
    logic signed [ACC_W-1:0]  act_y;
    logic                     div_go;
    logic                     div_done;
    logic signed [ACC_W-1:0]  div_q;
    logic signed [ACC_W-1:0]  res_val;
    logic [IDX_W-1:0]         res_idx;

    always_comb begin
        op_i     = op_e'(op);
        ctl.take = in_valid;
        ctl.clr  = start;
        ctl.fin  = in_valid & in_last;
        pc       = clamp_prec(int'(prec), DATA_W);
        for (int i = 0; i < DATA_W; i++)
            smp[i] = (i < pc) ? in_data[i] : in_data[pc-1];
    end

    rd_extreme #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ext (
        .clk(clk), .rst(rst), .clr(ctl.clr), .take(ctl.take),
        .want_min(op_i == OP_MIN), .smp(smp), .idx(in_idx),
        .nxt_val(ext_val), .nxt_idx(ext_idx)
    );

    rd_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst(rst), .clr(ctl.clr), .take(ctl.take), .smp(smp),
        .nxt_sum(nxt_sum), .nxt_cnt(nxt_cnt)
    );

    rd_activate #(.W(ACC_W)) u_act (
        .op(op_i), .x(nxt_sum), .thr(thresh), .y(act_y)
    );

    assign div_go = ctl.fin && (op_i == OP_MEAN);

    rd_divider #(.W(ACC_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .dividend(nxt_sum),
        .divisor(ACC_W'(nxt_cnt)), .done(div_done), .quotient(div_q)
    );

    always_comb begin
        res_idx = '0;
        case (op_i)
            OP_MAX, OP_MIN: begin
                res_val = {{(ACC_W-DATA_W){ext_val[DATA_W-1]}}, ext_val};
                res_idx = ext_idx;
            end
            OP_SUM:  res_val = nxt_sum;
            OP_THR, OP_RELU, OP_SIGN, OP_TANH, OP_SIGM: res_val = act_y;
            default: res_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (ctl.fin && (op_i != OP_MEAN)) begin
                out_valid <= 1'b1;
                out_value <= res_val;
                out_idx   <= res_idx;
            end
            if (div_done) begin
                out_valid <= 1'b1;
                out_value <= div_q;
                out_idx   <= '0;
            end
        end
    end
endmodule

// File: rtl/resid_decide_chk.sv
module resid_decide_chk
    import resid_decide_pkg::*;
#(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [3:0]          op,
    input logic                in_valid,
    input logic                in_last,
    input logic                out_valid,
    input logic signed [W-1:0] out_value,
    input logic                div_done
);
    logic fin;
    assign fin = in_valid && in_last;

    // R12: single-cycle opcodes answer on the next cycle
    p_single_next_r12: assert property (@(posedge clk) disable iff (rst)
        (fin && op != 4'(OP_MEAN)) |=> out_valid);

    // R12: a result pulse always has a cause one cycle earlier
    p_valid_cause_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(fin && op != 4'(OP_MEAN)) || $past(div_done)));

    // R6: mean never answers in the cycle after its last sample
    p_mean_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (fin && op == 4'(OP_MEAN)) |=> !out_valid);

    p_thr_binary_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(fin && op == 4'(OP_THR))) |-> (out_value == 0 || out_value == 1));

    p_relu_nonneg_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(fin && op == 4'(OP_RELU))) |-> !out_value[W-1]);

    p_sign_unit_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(fin && op == 4'(OP_SIGN))) |-> (out_value == 1 || out_value == -1));

    p_tanh_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(fin && op == 4'(OP_TANH))) |-> (out_value <= Q_ONE && out_value >= -Q_ONE));

    p_sigm_bound_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(fin && op == 4'(OP_SIGM))) |-> (out_value <= Q_ONE && out_value >= 0));
endmodule

bind resid_decide resid_decide_chk #(.W(ACC_W)) u_chk (
    .clk(clk), .rst(rst), .op(op), .in_valid(in_valid), .in_last(in_last),
    .out_valid(out_valid), .out_value(out_value), .div_done(div_done)
);

// File: tb/test_resid_decide.sv
module test_resid_decide;
    import resid_decide_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0] op = '0;
    logic [3:0] prec = 4'd8;
    logic signed [15:0] thresh = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [7:0] in_idx = '0;
    logic in_last = 1'b0;
    logic out_valid;
    logic signed [15:0] out_value;
    logic [7:0] out_idx;

    int checks = 0;
    int errors = 0;
    logic [7:0] d_a [16];
    logic [7:0] x_a [16];

    always #2 clk = ~clk;

    resid_decide i_resid_decide (
        .clk(clk), .rst(rst), .start(start), .op(op), .prec(prec), .thresh(thresh),
        .in_valid(in_valid), .in_data(in_data), .in_idx(in_idx), .in_last(in_last),
        .out_valid(out_valid), .out_value(out_value), .out_idx(out_idx)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic put(input int k, input int v, input int ix);
        d_a[k] = 8'(v);
        x_a[k] = 8'(ix);
    endtask

    // Streams n samples (start on the first) and checks the result at its due cycle.
    task automatic run(input string tag, input int opc, input int pr, input int thr,
                       input int n, input int exp_v, input int exp_i);
        op = 4'(opc); prec = 4'(pr); thresh = 16'(thr);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start = (k == 0); in_valid = 1'b1;
            in_data = d_a[k]; in_idx = x_a[k]; in_last = (k == n - 1);
        end
        @(posedge clk); #1;
        if (opc == int'(OP_MEAN)) begin
            int lat = 0;
            chk(tag, "valid too early", int'(out_valid), 0);
            @(negedge clk);
            start = 0; in_valid = 0; in_last = 0;
            while (!out_valid && lat < 100) begin
                @(posedge clk); #1;
                lat++;
            end
            chk("R6", "mean latency", lat, 17);
        end else begin
            chk(tag, "valid", int'(out_valid), 1);
            @(negedge clk);
            start = 0; in_valid = 0; in_last = 0;
        end
        chk(tag, "value", int'(out_value), exp_v);
        chk(tag, "index", int'(out_idx), exp_i);
        @(posedge clk); #1;
        chk("R12", "valid is one pulse", int'(out_valid), 0);
    endtask

    function automatic int tanh_ref(input int s);
        int m, r;
        if (s >= 32) return 16;
        if (s <= -32) return -16;
        m = (s < 0) ? -s : s;
        if (m <= 8) r = m;
        else if (m <= 16) r = 8 + (m - 8) / 2;
        else r = 12 + (m - 16) / 4;
        return (s < 0) ? -r : r;
    endfunction

    function automatic int sigm_ref(input int s);
        if (s >= 32) return 16;
        if (s <= -32) return 0;
        return 8 + ((s >= 0) ? s / 4 : -((-s + 3) / 4));
    endfunction

    task automatic t_reset;
        chk("R1", "valid after reset", int'(out_valid), 0);
        chk("R1", "value after reset", int'(out_value), 0);
        chk("R1", "index after reset", int'(out_idx), 0);
    endtask

    task automatic t_max;
        put(0, 3, 10); put(1, -5, 11); put(2, 9, 12); put(3, 9, 13); put(4, 2, 14);
        run("R3", 0, 8, 0, 5, 9, 12);
        put(0, -7, 40); put(1, -3, 41); put(2, -3, 42);
        run("R3", 0, 8, 0, 3, -3, 41);
    endtask

    task automatic t_min;
        put(0, 4, 0); put(1, -6, 1); put(2, 1, 2); put(3, -6, 3);
        run("R4", 1, 8, 0, 4, -6, 1);
        put(0, -128, 200);
        run("R4", 1, 8, 0, 1, -128, 200);
    endtask

    task automatic t_sum;
        put(0, 10, 5); put(1, 20, 6); put(2, -5, 7);
        run("R5", 3, 8, 0, 3, 25, 0);
        run("R5", 12, 8, 0, 3, 0, 0);
    endtask

    task automatic t_prec;
        put(0, 8'h0F, 0); put(1, 8'h07, 1); put(2, 8'h38, 2);
        run("R2", 3, 4, 0, 3, -2, 0);
        run("R2", 3, 2, 0, 3, -2, 0);
        run("R2", 3, 15, 0, 3, 78, 0);
        put(0, 8'h3F, 0);
        run("R2", 3, 6, 0, 1, -1, 0);
    endtask

    task automatic t_mean;
        put(0, 10, 0); put(1, 20, 1); put(2, -5, 2);
        run("R6", 2, 8, 0, 3, 8, 0);
        put(0, -7, 0); put(1, -8, 1);
        run("R6", 2, 8, 0, 2, -7, 0);
    endtask

    task automatic t_thr;
        put(0, 10, 0); put(1, 20, 1); put(2, -5, 2);
        run("R7", 4, 8, 25, 3, 1, 0);
        run("R7", 4, 8, 26, 3, 0, 0);
        run("R7", 4, 8, -30, 3, 1, 0);
    endtask

    task automatic t_relu_sign;
        put(0, 2, 0); put(1, -5, 1);
        run("R8", 5, 8, 0, 2, 0, 0);
        run("R9", 6, 8, 0, 2, -1, 0);
        put(0, 25, 0);
        run("R8", 5, 8, 0, 1, 25, 0);
        put(0, 0, 0);
        run("R9", 6, 8, 0, 1, 1, 0);
    endtask

    task automatic t_curves;
        int xs [8] = '{5, 12, 20, 40, -12, -40, 0, -10};
        foreach (xs[k]) begin
            put(0, xs[k], 0);
            run("R10", 7, 8, 0, 1, tanh_ref(xs[k]), 0);
            run("R11", 8, 8, 0, 1, sigm_ref(xs[k]), 0);
        end
    endtask

    task automatic t_restart;
        put(0, 100, 9);
        run("R13", 0, 8, 0, 1, 100, 9);
        put(0, 5, 3); put(1, 4, 4);
        run("R13", 0, 8, 0, 2, 5, 3);
        put(0, 50, 1); put(1, 7, 2);
        run("R13", 3, 8, 0, 2, 57, 0);
        put(0, 1, 0);
        run("R13", 3, 8, 0, 1, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset;
        t_max;
        t_min;
        t_sum;
        t_prec;
        t_mean;
        t_thr;
        t_relu_sign;
        t_curves;
        t_restart;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule